// File: doc/BRIEF.md
# ADC Command Register Interface

This block sits between a processor register bus and a bank of 16-bit converter registers. Software reaches it through seven 32-bit registers: configuration, interrupt status, interrupt mask, misc status, command queue, result queue and misc control. A word written to the command queue is decoded and carried out at once against the internal bank. The result goes into a result queue, and software drains that queue one entry per read.

The interrupt scheme is masked and write-one-to-clear. Commands never wait, so the "command queue below threshold" status bit is always set. A second status bit is set while the result queue holds more entries than the threshold programmed in the configuration register. Each register has its own access rule. An access that breaks the rule changes nothing, and a read that breaks it returns zero. The bus has one read strobe and one write strobe, and read data is registered.

Top module: `adc_cmd_regif`

## Requirements
- R1: After reset, configuration reads 0x00001814, interrupt status 0x00000200, interrupt mask 0xFFFFFFFF, misc status 0x00000500 and misc control 0x00000010. The bank holds zeros, the result queue is empty and irq is low.
- R2: Registers sit at byte offsets: configuration 0x00, interrupt status 0x04, mask 0x08, misc status 0x0C, command queue 0x10, result queue 0x14, misc control 0x18. Read data appears on rd_data one cycle after the read strobe and holds until the next read.
- R3: A command word has its opcode in bits 29:26, the bank address in bits 25:16 and data in bits 15:0. Opcode 1 queues the addressed bank word. Opcode 2 stores the data and queues zero. Opcode 0 queues zero. Every other opcode does nothing.
- R4: While misc control bit 4 is set, command words are dropped with no effect.
- R5: A read or write command whose bank address is 128 or more is dropped. A no-op is never dropped for its address.
- R6: Reading the result queue pops the oldest entry, or returns zero when the queue is empty. The queue holds 15 entries, and a push into a full queue is lost.
- R7: Misc status reads the queue level in bits 15:12, full in bit 9 and empty in bit 8, with bit 10 always set and every other bit zero.
- R8: Writing interrupt status clears each bit written as one. Bit 9 is always set again. Bit 8 is set whenever the queue level exceeds configuration bits 19:16.
- R9: A mask write keeps only bits 9:0. irq is high exactly when a status bit is set and its mask bit is clear.
- R10: Writes to misc status, the result queue or any offset above 0x18 are ignored. Reads of the command queue or any offset above 0x18 return zero.
- R11: Configuration takes any 32-bit value. A misc control write keeps only the bits set in 0x00FFFEFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
Commands are sent with each opcode, including an unused one. The bank addresses used are the lowest, the highest valid one, the first invalid one and the largest field value. This separates a correct range check from one that truncates the address or applies the check to no-ops. The queue is filled past its depth and drained past empty, which exposes lost pushes, full and empty flags and data order. Mask and threshold values are varied while the queue level moves, so that each status bit alone can be shown to drive the interrupt.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;

  typedef enum logic [2:0] {
    RegCfg  = 3'd0,
    RegSts  = 3'd1,
    RegMsk  = 3'd2,
    RegInfo = 3'd3,
    RegCmdQ = 3'd4,
    RegResQ = 3'd5,
    RegCtl  = 3'd6
  } reg_sel_e;

  localparam logic [3:0]  OpNop = 4'd0;
  localparam logic [3:0]  OpRd  = 4'd1;
  localparam logic [3:0]  OpWr  = 4'd2;

  localparam int          IntW      = 10;
  localparam int          BitCmdLow = 9;
  localparam int          BitResHi  = 8;
  localparam logic [31:0] CfgReset  = 32'h0000_1814;
  localparam logic [31:0] CtlReset  = 32'h0000_0010;
  localparam logic [31:0] CtlWMask  = 32'h00FF_FEFF;
  localparam int          CtlHoldBit = 4;

  typedef struct packed {
    logic     cfgWr;
    logic     stsWr;
    logic     mskWr;
    logic     ctlWr;
    logic     bankWr;
    logic     pushRd;
    logic     pushZero;
    logic     pop;
    logic     rdEn;
    logic     rdLegal;
    reg_sel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/adc_cmd_ctrl.sv
module adc_cmd_ctrl
  import adc_cmd_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int BANK_DEPTH = 128
) (
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [13:0]      cmdField,
  input  logic             chanHold,
  input  logic             resEmpty,
  output strobe_t          strb
);

  logic       inRange, wrLegal, rdLegal, cmdGo, tgtOk;
  logic [3:0] op;
  logic [9:0] tgt;

  assign inRange = regIdx <= IDX_W'(RegCtl);
  assign wrLegal = inRange && (regIdx != IDX_W'(RegInfo)) && (regIdx != IDX_W'(RegResQ));
  assign rdLegal = inRange && (regIdx != IDX_W'(RegCmdQ));
  assign op      = cmdField[13:10];
  assign tgt     = cmdField[9:0];
  assign tgtOk   = int'(tgt) < BANK_DEPTH;
  assign cmdGo   = wrEn && wrLegal && (regIdx == IDX_W'(RegCmdQ)) && !chanHold;

  always_comb begin
    strb          = '0;
    strb.cfgWr    = wrEn && (regIdx == IDX_W'(RegCfg));
    strb.stsWr    = wrEn && (regIdx == IDX_W'(RegSts));
    strb.mskWr    = wrEn && (regIdx == IDX_W'(RegMsk));
    strb.ctlWr    = wrEn && (regIdx == IDX_W'(RegCtl));
    strb.bankWr   = cmdGo && (op == OpWr) && tgtOk;
    strb.pushRd   = cmdGo && (op == OpRd) && tgtOk;
    strb.pushZero = cmdGo && (((op == OpWr) && tgtOk) || (op == OpNop));
    strb.pop      = rdEn && (regIdx == IDX_W'(RegResQ)) && !resEmpty;
    strb.rdEn     = rdEn;
    strb.rdLegal  = rdLegal;
    strb.rdSel    = reg_sel_e'(regIdx[2:0]);
  end

endmodule

// File: rtl/adc_cmd_dp.sv
module adc_cmd_dp
  import adc_cmd_pkg::*;
#(
  parameter int BANK_DEPTH = 128,
  parameter int FIFO_DEPTH = 15
) (
  input  logic        clk,
  input  logic        rst,
  input  strobe_t     strb,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irq,
  output logic        chanHold,
  output logic        resEmpty
);

  localparam int BankAw = $clog2(BANK_DEPTH);
  localparam int PtrW   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CntW   = $clog2(FIFO_DEPTH + 1);

  logic [31:0]     cfgQ, mskQ, ctlQ, cfgNext, infoVal, rdNext;
  logic [IntW-1:0] stsQ, stsNext, clrBits;
  logic [15:0]     bankQ [BANK_DEPTH];
  logic [15:0]     fifoQ [FIFO_DEPTH];
  logic [PtrW-1:0] headQ, tailQ;
  logic [CntW-1:0] cntQ, cntNext;
  logic [BankAw-1:0] bankIdx;
  logic [15:0]     pushVal;
  logic            pushEn, full;

  assign bankIdx  = wrData[16 +: BankAw];
  assign full     = cntQ == CntW'(FIFO_DEPTH);
  assign resEmpty = cntQ == '0;
  assign pushEn   = (strb.pushRd || strb.pushZero) && !full;
  assign pushVal  = strb.pushRd ? bankQ[bankIdx] : 16'h0000;
  assign cntNext  = cntQ + CntW'(pushEn) - CntW'(strb.pop);
  assign cfgNext  = strb.cfgWr ? wrData : cfgQ;
  assign clrBits  = strb.stsWr ? wrData[IntW-1:0] : '0;

  always_comb begin
    stsNext            = stsQ & ~clrBits;
    stsNext[BitCmdLow] = 1'b1;
    if (int'(cntNext) > int'(cfgNext[19:16])) stsNext[BitResHi] = 1'b1;
  end

  function automatic logic [PtrW-1:0] ptrInc(input logic [PtrW-1:0] p);
    return (int'(p) == FIFO_DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    infoVal        = '0;
    infoVal[15:12] = 4'(cntQ);
    infoVal[10]    = 1'b1;
    infoVal[9]     = full;
    infoVal[8]     = resEmpty;
  end

  always_comb begin
    rdNext = '0;
    if (strb.rdLegal) begin
      unique case (strb.rdSel)
        RegCfg:  rdNext = cfgQ;
        RegSts:  rdNext = {{(32-IntW){1'b0}}, stsQ};
        RegMsk:  rdNext = mskQ;
        RegInfo: rdNext = infoVal;
        RegResQ: rdNext = resEmpty ? 32'h0 : {16'h0, fifoQ[headQ]};
        RegCtl:  rdNext = ctlQ;
        default: rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ   <= CfgReset;
      stsQ   <= IntW'(1) << BitCmdLow;
      mskQ   <= '1;
      ctlQ   <= CtlReset;
      headQ  <= '0;
      tailQ  <= '0;
      cntQ   <= '0;
      rdData <= '0;
    end else begin
      cfgQ <= cfgNext;
      stsQ <= stsNext;
      cntQ <= cntNext;
      if (strb.mskWr) mskQ <= {{(32-IntW){1'b0}}, wrData[IntW-1:0]};
      if (strb.ctlWr) ctlQ <= wrData & CtlWMask;
      if (pushEn)     tailQ <= ptrInc(tailQ);
      if (strb.pop)   headQ <= ptrInc(headQ);
      if (strb.rdEn)  rdData <= rdNext;
    end
  end

  always_ff @(posedge clk) begin
    if (pushEn) fifoQ[tailQ] <= pushVal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BANK_DEPTH; i++) bankQ[i] <= '0;
    end else if (strb.bankWr) begin
      bankQ[bankIdx] <= wrData[15:0];
    end
  end

  assign irq      = |(stsQ & ~mskQ[IntW-1:0]);
  assign chanHold = ctlQ[CtlHoldBit];

endmodule

// File: rtl/adc_cmd_regif.sv
module adc_cmd_regif
  import adc_cmd_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BANK_DEPTH = 128,
  parameter int FIFO_DEPTH = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              irq
);

  localparam int IdxW = ADDR_W - 2;

  strobe_t strb;
  logic    chanHold, resEmpty;
  logic    unusedLsb;

  assign unusedLsb = ^addr[1:0];

  adc_cmd_ctrl #(.IDX_W(IdxW), .BANK_DEPTH(BANK_DEPTH)) ctrl_i (
    .wrEn     (wr_en),
    .rdEn     (rd_en),
    .regIdx   (addr[ADDR_W-1:2]),
    .cmdField (wr_data[29:16]),
    .chanHold (chanHold),
    .resEmpty (resEmpty),
    .strb     (strb)
  );

  adc_cmd_dp #(.BANK_DEPTH(BANK_DEPTH), .FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .wrData   (wr_data),
    .rdData   (rd_data),
    .irq      (irq),
    .chanHold (chanHold),
    .resEmpty (resEmpty)
  );

endmodule

// File: rtl/adc_cmd_regif_chk.sv
module adc_cmd_regif_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rd_data
);

  logic [ADDR_W-3:0] idx;
  logic              unusedLsb;
  assign idx       = addr[ADDR_W-1:2];
  assign unusedLsb = ^addr[1:0];

  // R2: read data changes only after a read strobe
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R10: command queue is write-only
  a_r10_cmdq_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == 4) |=> rd_data == 32'h0);

  // R10: offsets above the map read as zero
  a_r10_hole_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx > 6) |=> rd_data == 32'h0);

  // R8: command-low status bit always reads set
  a_r8_cmd_low_set: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == 1) |=> rd_data[9]);

  // R7: command queue always empty, upper half zero
  a_r7_info_fixed: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == 3) |=> (rd_data[10] && rd_data[31:16] == 16'h0));

  // R7: full and empty never both
  a_r7_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == 3) |=> !(rd_data[9] && rd_data[8]));

endmodule

bind adc_cmd_regif adc_cmd_regif_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .rd_en   (rd_en),
  .addr    (addr),
  .rd_data (rd_data)
);

// File: tb/adc_cmd_regif_tb_top.sv
module adc_cmd_regif_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_cmd_regif dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  // behavioural reference
  int unsigned mCfg, mSts, mMsk, mCtl;
  int unsigned mBank [128];
  int unsigned mQ [$];

  function automatic void mRefresh();
    mSts = mSts | 32'h200;
    if (mQ.size() > ((mCfg >> 16) & 15)) mSts = mSts | 32'h100;
  endfunction

  function automatic void mPush(int unsigned v);
    if (mQ.size() < 15) mQ.push_back(v);
  endfunction

  function automatic void mWrite(int idx, int unsigned v);
    int unsigned op, tgt;
    case (idx)
      0: mCfg = v;
      1: mSts = mSts & ~v;
      2: mMsk = v & 32'h3FF;
      4: if ((mCtl & 32'h10) == 0) begin
           op  = (v >> 26) & 15;
           tgt = (v >> 16) & 32'h3FF;
           if (!(op != 0 && tgt >= 128)) begin
             if (op == 1) mPush(mBank[tgt]);
             else if (op == 2) begin mBank[tgt] = v & 32'hFFFF; mPush(0); end
             else if (op == 0) mPush(0);
           end
         end
      6: mCtl = v & 32'h00FFFEFF;
      default: ;
    endcase
    mRefresh();
  endfunction

  function automatic int unsigned mRead(int idx);
    int unsigned r = 0;
    int n = mQ.size();
    case (idx)
      0: r = mCfg;
      1: r = mSts;
      2: r = mMsk;
      3: r = 32'h400 | (n << 12) | ((n == 0) ? 32'h100 : 0) | ((n == 15) ? 32'h200 : 0);
      5: if (n > 0) r = mQ.pop_front();
      6: r = mCtl;
      default: r = 0;
    endcase
    mRefresh();
    return r;
  endfunction

  function automatic logic mIrq();
    return ((mSts & ~mMsk & 32'h3FF) != 0);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check("R9 irq", {31'b0, irq}, {31'b0, mIrq()});
  endtask

  task automatic busWrite(int idx, logic [31:0] v);
    wr_en = 1'b1; addr = 8'(idx * 4); wr_data = v;
    mWrite(idx, v);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic busRead(int idx, string tag);
    logic [31:0] expv;
    rd_en = 1'b1; addr = 8'(idx * 4);
    expv = mRead(idx);
    tick();
    rd_en = 1'b0;
    check(tag, rd_data, expv);
  endtask

  function automatic logic [31:0] cmd(int op, int tgt, int dat);
    return (32'(op) << 26) | (32'(tgt & 32'h3FF) << 16) | 32'(dat & 32'hFFFF);
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mCfg = 32'h1814; mSts = 32'h200; mMsk = 32'hFFFFFFFF; mCtl = 32'h10;
    foreach (mBank[i]) mBank[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();

    // R1 reset values
    busRead(0, "R1 cfg");
    busRead(1, "R1 sts");
    busRead(2, "R1 msk");
    busRead(3, "R1 info");
    busRead(6, "R1 ctl");
    busRead(5, "R1 empty queue");

    // R4 commands dropped while held
    busWrite(4, cmd(0, 0, 0));
    busWrite(4, cmd(2, 3, 16'h5555));
    busRead(3, "R4 nothing queued");

    // R11 control mask, release hold
    busWrite(6, 32'hFFFFFFFF);
    busRead(6, "R11 ctl mask");
    busWrite(4, cmd(0, 0, 0));
    busRead(3, "R4 still held");
    busWrite(6, 32'h0);
    busRead(6, "R11 ctl cleared");

    // R11 configuration full width
    busWrite(0, 32'hA5A5_5A5A);
    busRead(0, "R11 cfg");
    busWrite(0, 32'h0003_1814);

    // R3 command decode, R9 mask
    busWrite(2, 32'h0);
    busWrite(4, cmd(2, 5, 16'h1234));
    busWrite(4, cmd(2, 127, 16'hBEEF));
    busWrite(4, cmd(1, 5, 0));
    busWrite(4, cmd(1, 127, 0));
    busWrite(4, cmd(0, 0, 0) | 32'hC000_0000);
    busWrite(4, cmd(1, 0, 0));
    busWrite(4, cmd(3, 5, 0));
    busWrite(4, cmd(15, 5, 0));
    busRead(1, "R8 level above threshold");
    busRead(3, "R7 level six");
    busWrite(2, 32'hFFFF_FDFF);
    busRead(2, "R9 mask bits");

    // R5 out-of-range targets
    busWrite(4, cmd(1, 128, 0));
    busWrite(4, cmd(2, 1023, 16'h7777));
    busWrite(4, cmd(0, 1023, 0));
    busRead(3, "R5 only nop queued");

    // R6 drain in order, then past empty
    for (int i = 0; i < 9; i++) busRead(5, "R6 pop order");
    busRead(3, "R7 empty after drain");

    // R8 write-one-to-clear
    busRead(1, "R8 sticky bit");
    busWrite(1, 32'hFFFF_FFFF);
    busRead(1, "R8 cleared");
    busWrite(2, 32'h0);

    // R6 overflow
    for (int i = 0; i < 17; i++) busWrite(4, cmd(1, 5, 0));
    busRead(3, "R7 full");
    busRead(1, "R8 full above threshold");
    for (int i = 0; i < 16; i++) busRead(5, "R6 full drain");
    busWrite(0, 32'h000F_0000);
    busWrite(1, 32'h100);
    busRead(1, "R8 threshold max");

    // R10 illegal accesses
    busWrite(4, cmd(1, 127, 0));
    busWrite(3, 32'hFFFF_FFFF);
    busWrite(5, 32'hFFFF_FFFF);
    busWrite(7, 32'hFFFF_FFFF);
    busRead(3, "R10 info unchanged");
    busRead(4, "R10 cmdq read zero");
    busRead(7, "R10 hole read zero");
    busRead(0, "R10 cfg unchanged");
    busRead(5, "R10 queue entry kept");

    // R9 mask all then none
    busWrite(2, 32'hFFFF_FFFF);
    busRead(2, "R9 mask clipped");
    busWrite(2, 32'h0);
    busWrite(6, 32'h10);
    busWrite(4, cmd(0, 0, 0));
    busRead(3, "R4 hold again");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule